// File: doc/BRIEF.md
# Oversampled Serial Bit-Rate Strobe Generator

This block derives every timing strobe a serial transmitter and receiver pair needs from one functional clock. A modulo divisor counter turns the clock into an oversample tick. A second counter groups a programmable number of those ticks into one bit period. It marks the end of each bit period with a bit tick and marks the middle of the bit with one or two sample strobes. The bit rate is the clock frequency divided by the product of divisor and oversampling ratio. For example, a 24 MHz clock with divisor 250 and ratio 10 gives 9600 bit/s, and the same clock with divisor 1 and ratio 4 gives 6 Mbit/s.

Software picks the divisor and the ratio. The ratio is given as ratio minus one. A receiver pulses `resync` on a detected start edge so that the bit grid restarts at that edge. At low ratios the block takes two samples around mid-bit, one oversample tick apart, so that a majority or edge-tolerant receiver still has enough margin.

Top module: `baud_gen`

## Requirements
- R1: While enabled with a non-zero divisor D (13-bit field, 1 to 8191) and no resync, `os_tick` is a one-cycle pulse that repeats every D clock cycles; with D = 1 it is high on every cycle.
- R2: `bit_tick` pulses together with every R-th `os_tick`, where R is the effective ratio, so bit ticks repeat every D*R cycles and each bit period holds exactly R oversample ticks.
- R3: With `enable` low or `divisor` equal to 0, no strobe of any kind is produced from the next cycle on and both counters are cleared; once running again, the first `bit_tick` comes D*R cycles after the change, counted from the first clock edge that sees the block running as cycle 1.
- R4: `osr_m1` (5 bits) holds R-1, so R can range from 4 to 32; field values 0, 1 and 2 act as R = 4.
- R5: Number the oversample ticks of a bit period 0 to R-1, starting after a `bit_tick`. In single-sample mode `sample_stb` pulses only with tick floor(R/2), once per bit, and never together with `bit_tick`.
- R6: In dual-sample mode `sample_stb` also pulses with tick floor(R/2)-1, giving two strobes per bit.
- R7: Dual-sample mode is chosen when `both_edge` is 1, and it is forced for every effective R below 8 whatever `both_edge` is. At R = 8 and above it follows `both_edge`.
- R8: A `resync` pulse clears both counters and silences all strobes on the next cycle. The first `bit_tick` after it comes D*R cycles after the clock edge that sampled `resync`.
- R9: Reset clears all three strobes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator when high |
| divisor | input | 13 | Modulo divisor; 0 stops the generator |
| osr_m1 | input | 5 | Oversampling ratio minus one |
| both_edge | input | 1 | Requests two mid-bit samples per bit |
| resync | input | 1 | Restarts the bit grid |
| os_tick | output | 1 | Oversample tick |
| bit_tick | output | 1 | End of bit period |
| sample_stb | output | 1 | Mid-bit sample strobe |

## Verification
The bench builds the block with its default widths: a 13-bit divisor and a 5-bit ratio field, with forced dual sampling below a ratio of 8. These settings allow the full ratio range from the clamped values up to 32. They also allow the extreme divisor of 8191, the 6 Mbit/s setting at divisor 1, and the 9600 bit/s setting at divisor 250. Odd and even ratios on both sides of the forcing limit show where each sample falls relative to the bit boundary.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   localparam int unsigned DEF_DIV_W     = 13;
   localparam int unsigned DEF_OSR_W     = 5;
   localparam int unsigned DEF_MIN_RATIO = 4;
   localparam int unsigned DEF_DUAL_BELOW = 8;

   typedef enum logic {
      SMP_SINGLE = 1'b0,
      SMP_DUAL   = 1'b1
   } smp_mode_e;

   typedef struct packed {
      logic os;
      logic bt;
      logic smp;
   } strobe_t;

endpackage

// File: rtl/baud_cfg.sv
module baud_cfg
   import baud_gen_pkg::*;
#(
   parameter int unsigned OSR_W      = DEF_OSR_W,
   parameter int unsigned MIN_RATIO  = DEF_MIN_RATIO,
   parameter int unsigned DUAL_BELOW = DEF_DUAL_BELOW,
   parameter bit          FORCE_DUAL = 1'b1
) (
   input  logic [OSR_W-1:0] osr_m1,
   input  logic             both_edge,
   output logic [OSR_W-1:0] last_idx,
   output logic [OSR_W-1:0] mid_idx,
   output smp_mode_e        mode
);

   localparam int unsigned RW = OSR_W + 1;
   localparam logic [OSR_W-1:0] MIN_LAST = OSR_W'(MIN_RATIO - 1);
   localparam logic [RW-1:0]    DUAL_LIM = RW'(DUAL_BELOW);

   logic [RW-1:0] ratio;
   logic          low_ratio;

   always_comb begin
      last_idx = (osr_m1 < MIN_LAST) ? MIN_LAST : osr_m1;
      ratio    = {1'b0, last_idx} + RW'(1);
      mid_idx  = ratio[RW-1:1];
      low_ratio = (ratio < DUAL_LIM);
   end

   generate
      if (FORCE_DUAL) begin : g_forced
         assign mode = (both_edge || low_ratio) ? SMP_DUAL : SMP_SINGLE;
      end else begin : g_free
         logic unused_low;
         assign unused_low = low_ratio;
         assign mode = both_edge ? SMP_DUAL : SMP_SINGLE;
      end
   endgenerate

endmodule

// File: rtl/baud_div.sv
module baud_div #(
   parameter int unsigned DIV_W = baud_gen_pkg::DEF_DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] divisor,
   output logic             wrap
);

   localparam int unsigned CW = DIV_W + 1;

   logic [DIV_W-1:0] cnt;
   logic [CW-1:0]    cnt_nx;

   always_comb begin
      cnt_nx = {1'b0, cnt} + CW'(1);
      wrap   = !clr && (cnt_nx >= {1'b0, divisor});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr || wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt_nx[DIV_W-1:0];
      end
   end

endmodule

// File: rtl/baud_osr_seq.sv
module baud_osr_seq
   import baud_gen_pkg::*;
#(
   parameter int unsigned OSR_W = DEF_OSR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [OSR_W-1:0] last_idx,
   input  logic [OSR_W-1:0] mid_idx,
   input  smp_mode_e        mode,
   output strobe_t          stb
);

   logic [OSR_W-1:0] cnt;
   logic             at_last;
   logic             at_mid;
   logic             at_pre;

   always_comb begin
      at_last = (cnt >= last_idx);
      at_mid  = (cnt == mid_idx);
      at_pre  = (mode == SMP_DUAL) && (cnt == (mid_idx - OSR_W'(1)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         stb <= '0;
      end else if (clr) begin
         cnt <= '0;
         stb <= '0;
      end else if (adv) begin
         cnt     <= at_last ? '0 : cnt + OSR_W'(1);
         stb.os  <= 1'b1;
         stb.bt  <= at_last;
         stb.smp <= at_mid || at_pre;
      end else begin
         stb <= '0;
      end
   end

endmodule

// File: rtl/baud_gen.sv
module baud_gen
   import baud_gen_pkg::*;
#(
   parameter int unsigned DIV_W      = DEF_DIV_W,
   parameter int unsigned OSR_W      = DEF_OSR_W,
   parameter int unsigned MIN_RATIO  = DEF_MIN_RATIO,
   parameter int unsigned DUAL_BELOW = DEF_DUAL_BELOW,
   parameter bit          FORCE_DUAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] divisor,
   input  logic [OSR_W-1:0] osr_m1,
   input  logic             both_edge,
   input  logic             resync,
   output logic             os_tick,
   output logic             bit_tick,
   output logic             sample_stb
);

   generate
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div
         $error("baud_gen: DIV_W out of range");
      end
      if (MIN_RATIO < 3 || MIN_RATIO > (1 << OSR_W)) begin : g_bad_min
         $error("baud_gen: MIN_RATIO must fit the ratio field and be at least 3");
      end
      if (DUAL_BELOW > (1 << OSR_W) + 1) begin : g_bad_dual
         $error("baud_gen: DUAL_BELOW beyond ratio range");
      end
   endgenerate

   logic             clr;
   logic             adv;
   logic [OSR_W-1:0] last_idx;
   logic [OSR_W-1:0] mid_idx;
   smp_mode_e        mode;
   strobe_t          stb;

   assign clr = !enable || (divisor == '0) || resync;

   baud_cfg #(
      .OSR_W      (OSR_W),
      .MIN_RATIO  (MIN_RATIO),
      .DUAL_BELOW (DUAL_BELOW),
      .FORCE_DUAL (FORCE_DUAL)
   ) i_cfg (
      .osr_m1    (osr_m1),
      .both_edge (both_edge),
      .last_idx  (last_idx),
      .mid_idx   (mid_idx),
      .mode      (mode)
   );

   baud_div #(
      .DIV_W (DIV_W)
   ) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .divisor (divisor),
      .wrap    (adv)
   );

   baud_osr_seq #(
      .OSR_W (OSR_W)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .adv      (adv),
      .last_idx (last_idx),
      .mid_idx  (mid_idx),
      .mode     (mode),
      .stb      (stb)
   );

   assign os_tick    = stb.os;
   assign bit_tick   = stb.bt;
   assign sample_stb = stb.smp;

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
   parameter int unsigned DIV_W = 13,
   parameter int unsigned OSR_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [DIV_W-1:0] divisor,
   input logic [OSR_W-1:0] osr_m1,
   input logic             both_edge,
   input logic             resync,
   input logic             os_tick,
   input logic             bit_tick,
   input logic             sample_stb
);

   logic unused_cfg;
   assign unused_cfg = ^{osr_m1, both_edge};

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || divisor == '0) |=> (!os_tick && !bit_tick && !sample_stb))
      else $error("p_idle_r3");

   p_resync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (!os_tick && !bit_tick && !sample_stb))
      else $error("p_resync_quiet_r8");

   p_bit_has_os_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> os_tick)
      else $error("p_bit_has_os_r2");

   p_smp_has_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (os_tick && !bit_tick))
      else $error("p_smp_has_os_r5");

   p_div1_dense_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(enable) && $past(divisor) == DIV_W'(1) && !$past(resync))
         |-> os_tick)
      else $error("p_div1_dense_r1");

   p_reset_r9: assert property (@(posedge clk)
      !rst_n |-> (!os_tick && !bit_tick && !sample_stb))
      else $error("p_reset_r9");

endmodule

bind baud_gen baud_gen_chk #(
   .DIV_W (DIV_W),
   .OSR_W (OSR_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .divisor    (divisor),
   .osr_m1     (osr_m1),
   .both_edge  (both_edge),
   .resync     (resync),
   .os_tick    (os_tick),
   .bit_tick   (bit_tick),
   .sample_stb (sample_stb)
);

// File: tb/test_baud_gen.sv
module test_baud_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [12:0] divisor = '0;
   logic [4:0]  osr_m1 = '0;
   logic        both_edge = 1'b0;
   logic        resync = 1'b0;
   logic        os_tick, bit_tick, sample_stb;

   int checks = 0;
   int failures = 0;
   int wd = 0;

   always #4 clk = ~clk;

   baud_gen i_baud_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .divisor(divisor),
      .osr_m1(osr_m1), .both_edge(both_edge), .resync(resync),
      .os_tick(os_tick), .bit_tick(bit_tick), .sample_stb(sample_stb));

   typedef struct packed {
      logic [12:0] div;
      logic [4:0]  fld;
      logic        be;
      logic [15:0] period;
      logic [5:0]  nos;
      logic [1:0]  nsmp;
      logic [5:0]  first;
   } vec_t;

   // div, field, both_edge, D*R, R, strobes per bit, first sample index
   localparam vec_t VECS [8] = '{
      '{13'd1,   5'd3,  1'b0, 16'd4,    6'd4,  2'd2, 6'd1},
      '{13'd3,   5'd15, 1'b0, 16'd48,   6'd16, 2'd1, 6'd8},
      '{13'd3,   5'd15, 1'b1, 16'd48,   6'd16, 2'd2, 6'd7},
      '{13'd2,   5'd31, 1'b0, 16'd64,   6'd32, 2'd1, 6'd16},
      '{13'd5,   5'd0,  1'b0, 16'd20,   6'd4,  2'd2, 6'd1},
      '{13'd250, 5'd9,  1'b0, 16'd2500, 6'd10, 2'd1, 6'd5},
      '{13'd1,   5'd6,  1'b0, 16'd7,    6'd7,  2'd2, 6'd2},
      '{13'd4,   5'd7,  1'b0, 16'd32,   6'd8,  2'd1, 6'd4}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_to_bit(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!bit_tick && n < 70000);
   endtask

   task automatic run_vec(input vec_t v, input int k);
      int n, os, smp, first, early;
      bit last_bt;
      divisor = v.div; osr_m1 = v.fld; both_edge = v.be; resync = 1'b1;
      @(negedge clk);
      resync = 1'b0;
      count_to_bit(n);
      chk(n == int'(v.period), $sformatf("R8 vec%0d resync to bit", k), n, v.period);
      os = 0; smp = 0; first = -1; early = 0; last_bt = 1'b0;
      for (int j = 1; j <= int'(v.period); j++) begin
         @(negedge clk);
         if (os_tick) begin
            if (sample_stb) begin
               smp++;
               if (first < 0) first = os;
            end
            os++;
         end
         if (bit_tick && j != int'(v.period)) early++;
         if (j == int'(v.period)) last_bt = bit_tick;
      end
      chk(os == int'(v.nos), $sformatf("R2 R4 vec%0d os per bit", k), os, v.nos);
      chk(early == 0 && last_bt, $sformatf("R2 vec%0d bit period", k), early, 0);
      chk(smp == int'(v.nsmp), $sformatf("R6 R7 vec%0d samples per bit", k), smp, v.nsmp);
      chk(first == int'(v.first), $sformatf("R5 vec%0d sample index", k), first, v.first);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n, cnt;
      enable = 1'b1; divisor = 13'd1; osr_m1 = 5'd3;
      repeat (3) @(negedge clk);
      // R9: reset holds strobes low even while configured to run
      chk(!os_tick && !bit_tick && !sample_stb, "R9 reset state",
          {os_tick, bit_tick, sample_stb}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < 8; k++) run_vec(VECS[k], k);

      // R1: largest divisor, os tick spacing
      divisor = 13'd8191; osr_m1 = 5'd3; resync = 1'b1;
      @(negedge clk);
      resync = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!os_tick && n < 20000);
      chk(n == 8191, "R1 first os tick after resync", n, 8191);
      n = 0;
      do begin @(negedge clk); n++; end while (!os_tick && n < 20000);
      chk(n == 8191, "R1 os tick spacing", n, 8191);

      // R1: divisor 1 gives os tick every cycle
      divisor = 13'd1; osr_m1 = 5'd15;
      @(negedge clk);
      cnt = 0;
      for (int j = 0; j < 20; j++) begin @(negedge clk); if (os_tick) cnt++; end
      chk(cnt == 20, "R1 divisor one dense", cnt, 20);

      // R3: enable low silences everything
      enable = 1'b0;
      @(negedge clk);
      cnt = 0;
      for (int j = 0; j < 40; j++) begin
         @(negedge clk);
         if (os_tick || bit_tick || sample_stb) cnt++;
      end
      chk(cnt == 0, "R3 disabled quiet", cnt, 0);

      // R3: divisor zero silences everything
      enable = 1'b1; divisor = 13'd0;
      @(negedge clk);
      cnt = 0;
      for (int j = 0; j < 40; j++) begin
         @(negedge clk);
         if (os_tick || bit_tick || sample_stb) cnt++;
      end
      chk(cnt == 0, "R3 divisor zero quiet", cnt, 0);

      // R3: restart from divisor zero, D=3 R=16
      divisor = 13'd3; osr_m1 = 5'd15; both_edge = 1'b0;
      count_to_bit(n);
      chk(n == 48, "R3 restart to first bit", n, 48);

      // R3: restart from enable low, D=2 R=8
      enable = 1'b0; divisor = 13'd2; osr_m1 = 5'd7;
      repeat (5) @(negedge clk);
      enable = 1'b1;
      count_to_bit(n);
      chk(n == 16, "R3 re-enable to first bit", n, 16);

      // R7: ratio 8 with both_edge request gives two samples
      divisor = 13'd1; osr_m1 = 5'd7; both_edge = 1'b1; resync = 1'b1;
      @(negedge clk);
      resync = 1'b0;
      count_to_bit(n);
      cnt = 0;
      for (int j = 0; j < 8; j++) begin @(negedge clk); if (sample_stb) cnt++; end
      chk(cnt == 2, "R7 ratio eight requested dual", cnt, 2);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule